// File: doc/BRIEF.md
# Hashed Page Table Search Engine

This block walks a hashed page table in memory after a translation lookaside buffer (TLB) miss. The caller supplies the virtual segment identifier of the access, the abbreviated page index (the six most significant bits of the page index), the access type, a protection-violation flag and two precomputed group base addresses, one primary and one secondary. All of these are captured on a one-cycle `start` pulse. Each group holds eight 64-bit entries. The engine reads the first word of each entry over a single-outstanding request/acknowledge memory port and compares it with the access. It covers the whole primary group before it touches the secondary group.

On the first matching entry the engine reads the entry's second word and sets the referenced bit in it. It also sets the changed bit when the access is a write and no protection violation was flagged. It then presents the whole entry, with the updated second word, on a one-cycle TLB fill port. It writes the second word back to memory only when a bit actually changed, and finally pulses `done`. When neither group contains a match, it pulses `fault` and leaves both the TLB and memory untouched.

Hash computation, the TLB array, caching and protection checking sit outside this block.

Top module: `hpt_search`

## Requirements
- R1: The search reads the first word of entries 0 to 7 of the primary group, then entries 0 to 7 of the secondary group, and stops at the first match. The first word of entry i is at base + 8*i and the second word at base + 8*i + 4. Only a matched entry has its second word read or written.
- R2: A first word matches in the primary group when bit 31 (valid) is 1, bit 6 (hash select) is 0, bits 30:7 equal `acc_vsid`, and bits 5:0 equal `acc_api`.
- R3: A first word matches in the secondary group under the same conditions, except that bit 6 must be 1.
- R4: When no entry of either group matches, exactly 16 reads are made, `fault` pulses for one cycle, and there is no TLB fill and no memory write.
- R5: On a match, `tlb_fill` pulses once, with `tlb_hi` equal to the first word and `tlb_lo` equal to the updated second word, and then `done` pulses for one cycle.
- R6: The referenced bit (bit 8 of the second word) is set in the updated word. The single write-back of the second word is skipped when the updated word equals the word that was read.
- R7: The changed bit (bit 7 of the second word) is set only when `acc_write` is 1 and `acc_prot_viol` is 0. Otherwise it keeps the value read from memory.
- R8: Every memory request carries `mem_mode` = 3'b001 (cacheable).
- R9: Once raised, `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until the cycle in which `mem_ack` is sampled high. That cycle completes the transfer.
- R10: `start` is ignored while `busy` is high, and the access inputs are used only as captured on an accepted `start`. With `busy` low, no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search (ignored while busy) |
| acc_vsid | input | 24 | Virtual segment identifier of the access |
| acc_api | input | 6 | Six most significant bits of the page index |
| acc_write | input | 1 | Access is a store |
| acc_prot_viol | input | 1 | Protection check failed for this access |
| pri_base | input | 32 | Primary group base address, 64-byte aligned |
| sec_base | input | 32 | Secondary group base address, 64-byte aligned |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: search ended with a hit |
| fault | output | 1 | One-cycle pulse: page fault, no match |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_mode | output | 3 | Memory attribute, always 3'b001 |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| tlb_fill | output | 1 | One-cycle TLB write strobe |
| tlb_hi | output | 32 | First word of the matched entry |
| tlb_lo | output | 32 | Second word of the matched entry, updated |

## Verification
The assertions check on every cycle the request hold rule, the cacheable attribute, and the referenced bit in every write-back and every fill. They also check that done and fault never coincide, that done lasts one cycle, that a fault follows a read, and that the memory port is quiet while idle. The bench scenarios show what depends on table contents. That covers the scan order and read counts, and the effect of the hash-select and valid bits, including decoys that differ only in one of them. It also covers when the changed bit is set under write and protection combinations, the skipped write-back, and a start pulse during a search being ignored.

// File: rtl/hpt_pkg.sv
// Shared constants and types for the hashed page table search engine.
// Assumes 32-bit memory words and 64-bit entries stored as two words.
package hpt_pkg;
    localparam logic [2:0] MODE_CACHED = 3'b001;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_TAG,
        S_RD_ATTR,
        S_FILL,
        S_WR_ATTR,
        S_DONE,
        S_FAULT
    } walk_st_t;
endpackage

// File: rtl/hpt_match.sv
// Compares one entry's first word against the access.
// Field layout (LSB-0): valid at the top bit, then VSID, then hash select,
// then the abbreviated page index in the low bits.
module hpt_match #(
    parameter int WORD_W = 32,
    parameter int VSID_W = 24,
    parameter int API_W  = 6
) (
    input  logic [WORD_W-1:0] tag_word,
    input  logic [VSID_W-1:0] vsid,
    input  logic [API_W-1:0]  api,
    input  logic              hsel,
    output logic              hit
);
    localparam int V_POS = WORD_W - 1;
    localparam int H_POS = WORD_W - 2 - VSID_W;

    // Combinational compare of all four fields.
    always_comb begin
        hit = tag_word[V_POS]
            && (tag_word[H_POS] == hsel)
            && (tag_word[V_POS-1 -: VSID_W] == vsid)
            && (tag_word[API_W-1:0] == api);
    end
endmodule

// File: rtl/hpt_addr.sv
// Forms the byte address of an entry word from a group base and an index.
// Assumes 8-byte entries; the second word sits 4 bytes above the first.
module hpt_addr #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic              second_word,
    output logic [ADDR_W-1:0] addr
);
    // Offset = 8*idx + 4*second_word, added to the base.
    always_comb begin
        logic [ADDR_W-1:0] off;
        off = '0;
        off[IDX_W+2:0] = {idx, second_word, 2'b00};
        addr = base + off;
    end
endmodule

// File: rtl/hpt_attr_upd.sv
// Computes the updated second word: referenced bit always set, changed bit
// set for an unprotected write. Flags whether anything changed.
module hpt_attr_upd #(
    parameter int WORD_W = 32,
    parameter int R_POS  = 8,
    parameter int C_POS  = 7
) (
    input  logic [WORD_W-1:0] attr_in,
    input  logic              is_write,
    input  logic              prot_viol,
    output logic [WORD_W-1:0] attr_out,
    output logic              changed
);
    // Set bits and compare against the original word.
    always_comb begin
        attr_out = attr_in;
        attr_out[R_POS] = 1'b1;
        if (is_write && !prot_viol) begin
            attr_out[C_POS] = 1'b1;
        end
        changed = (attr_out != attr_in);
    end
endmodule

// File: rtl/hpt_search.sv
// Hashed page table search engine. Scans the primary group, then the
// secondary group, fills the TLB on a hit and writes back R/C if needed.
// Assumes a single-outstanding req/ack memory port; request held until ack.
module hpt_search
    import hpt_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WORD_W  = 32,
    parameter int VSID_W  = 24,
    parameter int API_W   = 6,
    parameter int NUM_ENT = 8,
    parameter int R_POS   = 8,
    parameter int C_POS   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VSID_W-1:0] acc_vsid,
    input  logic [API_W-1:0]  acc_api,
    input  logic              acc_write,
    input  logic              acc_prot_viol,
    input  logic [ADDR_W-1:0] pri_base,
    input  logic [ADDR_W-1:0] sec_base,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [2:0]        mem_mode,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tlb_fill,
    output logic [WORD_W-1:0] tlb_hi,
    output logic [WORD_W-1:0] tlb_lo
);
    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENT - 1);

    walk_st_t          st;
    logic [VSID_W-1:0] vsid_q;
    logic [API_W-1:0]  api_q;
    logic              wr_q;
    logic              prot_q;
    logic [ADDR_W-1:0] pri_q;
    logic [ADDR_W-1:0] sec_q;
    logic              sec_sel;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] tag_q;
    logic [WORD_W-1:0] attr_q;
    logic              chg_q;

    logic              tag_hit;
    logic [WORD_W-1:0] attr_new;
    logic              attr_chg;
    logic [ADDR_W-1:0] grp_base;

    // Select the group being scanned.
    always_comb grp_base = sec_sel ? sec_q : pri_q;

    hpt_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
        .base        (grp_base),
        .idx         (idx_q),
        .second_word (st != S_RD_TAG),
        .addr        (mem_addr)
    );

    hpt_match #(.WORD_W(WORD_W), .VSID_W(VSID_W), .API_W(API_W)) u_match (
        .tag_word (mem_rdata),
        .vsid     (vsid_q),
        .api      (api_q),
        .hsel     (sec_sel),
        .hit      (tag_hit)
    );

    hpt_attr_upd #(.WORD_W(WORD_W), .R_POS(R_POS), .C_POS(C_POS)) u_upd (
        .attr_in   (mem_rdata),
        .is_write  (wr_q),
        .prot_viol (prot_q),
        .attr_out  (attr_new),
        .changed   (attr_chg)
    );

    // Search sequencer: capture on start, step through entries, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            vsid_q  <= '0;
            api_q   <= '0;
            wr_q    <= 1'b0;
            prot_q  <= 1'b0;
            pri_q   <= '0;
            sec_q   <= '0;
            sec_sel <= 1'b0;
            idx_q   <= '0;
            tag_q   <= '0;
            attr_q  <= '0;
            chg_q   <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (start) begin
                        vsid_q  <= acc_vsid;
                        api_q   <= acc_api;
                        wr_q    <= acc_write;
                        prot_q  <= acc_prot_viol;
                        pri_q   <= pri_base;
                        sec_q   <= sec_base;
                        sec_sel <= 1'b0;
                        idx_q   <= '0;
                        st      <= S_RD_TAG;
                    end
                end
                S_RD_TAG: begin
                    if (mem_ack) begin
                        if (tag_hit) begin
                            tag_q <= mem_rdata;
                            st    <= S_RD_ATTR;
                        end else if (idx_q == LAST_IDX) begin
                            if (sec_sel) begin
                                st <= S_FAULT;
                            end else begin
                                sec_sel <= 1'b1;
                                idx_q   <= '0;
                            end
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                S_RD_ATTR: begin
                    if (mem_ack) begin
                        attr_q <= attr_new;
                        chg_q  <= attr_chg;
                        st     <= S_FILL;
                    end
                end
                S_FILL:    st <= chg_q ? S_WR_ATTR : S_DONE;
                S_WR_ATTR: if (mem_ack) st <= S_DONE;
                default:   st <= S_IDLE;
            endcase
        end
    end

    // Output decode from the current state.
    always_comb begin
        busy      = (st != S_IDLE);
        done      = (st == S_DONE);
        fault     = (st == S_FAULT);
        mem_req   = (st == S_RD_TAG) || (st == S_RD_ATTR) || (st == S_WR_ATTR);
        mem_we    = (st == S_WR_ATTR);
        mem_wdata = attr_q;
        mem_mode  = MODE_CACHED;
        tlb_fill  = (st == S_FILL);
        tlb_hi    = tag_q;
        tlb_lo    = attr_q;
    end
endmodule

// File: rtl/hpt_search_chk.sv
// Protocol and invariant checker for hpt_search, attached by bind.
// Assumes the default field positions of the entry's second word.
module hpt_search_chk #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int R_POS  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fault,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic [2:0]        mem_mode,
    input logic              mem_ack,
    input logic              tlb_fill,
    input logic              fill_r
);
    AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault)); // R4
    AST_FAULT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(mem_req) && !$past(mem_we) && !$past(tlb_fill)); // R4
    AST_MODE_CACHED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_mode == 3'b001); // R8
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr)
            && $stable(mem_we) && $stable(mem_wdata)); // R9
    AST_WR_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[R_POS]); // R6
    AST_WR_SECOND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_addr[2]); // R1
    AST_FILL_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_fill |-> fill_r); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !tlb_fill); // R10
endmodule

bind hpt_search hpt_search_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .R_POS(R_POS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .fault     (fault),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_mode  (mem_mode),
    .mem_ack   (mem_ack),
    .tlb_fill  (tlb_fill),
    .fill_r    (tlb_lo[R_POS])
);

// File: tb/hpt_search_bench.sv
// Bench for hpt_search: memory model with random ack latency, random tables
// with planted hits and decoys, plus directed corner cases.
module hpt_search_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] acc_vsid = '0;
    logic [5:0]  acc_api = '0;
    logic        acc_write = 1'b0;
    logic        acc_prot_viol = 1'b0;
    logic [31:0] pri_base = '0;
    logic [31:0] sec_base = '0;
    logic        busy, done, fault, mem_req, mem_we, tlb_fill;
    logic [31:0] mem_addr, mem_wdata, tlb_hi, tlb_lo;
    logic [2:0]  mem_mode;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [31:0] mem [0:1023];
    int rd_cnt, wr_cnt, mode_err, fill_cnt, ack_wait;
    logic [31:0] cap_hi, cap_lo;

    always #5 clk = ~clk;

    hpt_search u_hpt_search (
        .clk(clk), .rst_n(rst_n), .start(start), .acc_vsid(acc_vsid),
        .acc_api(acc_api), .acc_write(acc_write), .acc_prot_viol(acc_prot_viol),
        .pri_base(pri_base), .sec_base(sec_base), .busy(busy), .done(done),
        .fault(fault), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_mode(mem_mode), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .tlb_fill(tlb_fill), .tlb_hi(tlb_hi), .tlb_lo(tlb_lo)
    );

    // Memory responder: serves one request at a time after a random wait.
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (ack_wait == 0) begin
                mem_ack <= 1'b1;
                if (mem_mode != 3'b001) mode_err++;
                if (mem_we) begin
                    mem[mem_addr[11:2]] = mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata <= mem[mem_addr[11:2]];
                    rd_cnt++;
                end
                ack_wait = $urandom % 3;
            end else begin
                ack_wait--;
            end
        end
    end

    // Capture TLB fills.
    always @(posedge clk) begin
        if (tlb_fill) begin
            fill_cnt++;
            cap_hi = tlb_hi;
            cap_lo = tlb_lo;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_tag(input logic v, input logic [23:0] vs,
                                           input logic h, input logic [5:0] api);
        return {v, vs, h, api};
    endfunction

    // Expected search result, computed from the requirement text.
    function automatic int exp_pos(input logic [23:0] vs, input logic [5:0] api,
                                   input logic [31:0] pb, input logic [31:0] sb);
        for (int g = 0; g < 2; g++) begin
            for (int i = 0; i < 8; i++) begin
                logic [31:0] w;
                w = mem[((g == 0 ? pb : sb) + 32'(8 * i)) >> 2];
                if (w[31] && w[6] == g[0] && w[30:7] == vs && w[5:0] == api)
                    return g * 8 + i;
            end
        end
        return -1;
    endfunction

    task automatic fill_random(input logic [31:0] pb, input logic [31:0] sb);
        for (int i = 0; i < 16; i++) begin
            mem[(pb >> 2) + i] = $urandom;
            mem[(sb >> 2) + i] = $urandom;
        end
    endtask

    task automatic run_case(input string tag, input logic [23:0] vs, input logic [5:0] api,
                            input logic wr, input logic prot,
                            input logic [31:0] pb, input logic [31:0] sb, input bit poke);
        int pos, wait_cyc, exp_rd;
        logic [31:0] base, w0, w1o, w1n;
        pos = exp_pos(vs, api, pb, sb);
        base = (pos >= 8) ? sb : pb;
        w0 = '0; w1o = '0; w1n = '0;
        if (pos >= 0) begin
            w0  = mem[(base + 32'(8 * (pos % 8))) >> 2];
            w1o = mem[(base + 32'(8 * (pos % 8)) + 4) >> 2];
            w1n = w1o | 32'h100 | ((wr && !prot) ? 32'h80 : 32'h0);
        end
        rd_cnt = 0; wr_cnt = 0; mode_err = 0; fill_cnt = 0;
        @(negedge clk);
        acc_vsid = vs; acc_api = api; acc_write = wr; acc_prot_viol = prot;
        pri_base = pb; sec_base = sb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        acc_vsid = ~vs; acc_api = ~api; acc_write = ~wr;
        if (poke) begin
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_cyc = 0;
        while (!(done || fault) && wait_cyc < 2000) begin
            @(negedge clk);
            wait_cyc++;
        end
        exp_rd = (pos < 0) ? 16 : pos + 2;
        if (pos < 0) begin
            chk({tag, " R4 fault"}, {30'd0, done, fault}, 32'd1);
            chk({tag, " R4 no fill"}, fill_cnt, 0);
            chk({tag, " R4 no write"}, wr_cnt, 0);
        end else begin
            chk({tag, " R5 done"}, {30'd0, done, fault}, 32'd2);
            chk({tag, " R5 fill count"}, fill_cnt, 1);
            chk({tag, " R5 tlb_hi R2 R3"}, cap_hi, w0);
            chk({tag, " R5 tlb_lo R7"}, cap_lo, w1n);
            chk({tag, " R6 write count"}, wr_cnt, (w1n != w1o) ? 1 : 0);
            chk({tag, " R6 R7 memory word"}, mem[(base + 32'(8 * (pos % 8)) + 4) >> 2], w1n);
        end
        chk({tag, " R1 read count"}, rd_cnt, exp_rd);
        chk({tag, " R8 mode"}, mode_err, 0);
        @(negedge clk);
        chk({tag, " R5 pulse end"}, {30'd0, done, fault}, 32'd0);
        chk({tag, " R10 idle after"}, {31'd0, busy}, 32'd0);
    endtask

    initial begin
        logic [31:0] pb, sb;
        logic [23:0] vs;
        logic [5:0]  api;
        void'($urandom(32'd20250611));
        ack_wait = 0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk("R10 reset busy", {31'd0, busy}, 32'd0);
        chk("R9 reset req", {31'd0, mem_req}, 32'd0);
        chk("R5 reset outputs", {29'd0, done, fault, tlb_fill}, 32'd0);
        rst_n = 1'b1;

        // Directed: primary entry 0 hit, R already set, read -> no write (R6).
        pb = 32'h0000_0040; sb = 32'h0000_0400; vs = 24'h12_3456; api = 6'h2a;
        fill_random(pb, sb);
        mem[pb >> 2] = mk_tag(1'b1, vs, 1'b0, api);
        mem[(pb >> 2) + 1] = 32'h0000_0100;
        run_case("d1", vs, api, 1'b0, 1'b0, pb, sb, 1'b0);

        // Directed: H=1 decoys in primary, hit at secondary entry 3 (R2 R3).
        fill_random(pb, sb);
        for (int i = 0; i < 8; i++) mem[(pb >> 2) + 2 * i] = mk_tag(1'b1, vs, 1'b1, api);
        mem[(sb >> 2) + 6] = mk_tag(1'b1, vs, 1'b1, api);
        run_case("d2", vs, api, 1'b0, 1'b0, pb, sb, 1'b0);

        // Directed: V=0 and H=0-in-secondary decoys only -> fault (R4).
        for (int i = 0; i < 8; i++) begin
            mem[(pb >> 2) + 2 * i] = mk_tag(1'b0, vs, 1'b0, api);
            mem[(sb >> 2) + 2 * i] = mk_tag(1'b1, vs, 1'b0, api);
        end
        run_case("d3", vs, api, 1'b1, 1'b0, pb, sb, 1'b0);

        // Directed: unprotected write sets C (R7).
        mem[(pb >> 2) + 4] = mk_tag(1'b1, vs, 1'b0, api);
        mem[(pb >> 2) + 5] = 32'h0000_0000;
        run_case("d4", vs, api, 1'b1, 1'b0, pb, sb, 1'b0);

        // Directed: write with protection violation leaves C clear (R7).
        mem[(pb >> 2) + 5] = 32'h0000_0000;
        run_case("d5", vs, api, 1'b1, 1'b1, pb, sb, 1'b0);

        // Directed: secondary entry 7, with a start pulse mid-search (R10).
        fill_random(pb, sb);
        mem[(sb >> 2) + 14] = mk_tag(1'b1, vs, 1'b1, api);
        mem[pb >> 2] = mk_tag(1'b1, ~vs, 1'b0, ~api);
        run_case("d6", vs, api, 1'b0, 1'b0, pb, sb, 1'b1);

        // Random: planted hits, decoys and misses.
        for (int n = 0; n < 60; n++) begin
            int kind, g1, g2, ix;
            g1 = $urandom % 64;
            g2 = (g1 + 1 + ($urandom % 63)) % 64;
            pb = 32'(g1 * 64); sb = 32'(g2 * 64);
            vs = 24'($urandom); api = 6'($urandom);
            fill_random(pb, sb);
            kind = $urandom % 4;
            ix = $urandom % 8;
            if (kind == 1) mem[(pb >> 2) + 2 * ix] = mk_tag(1'b1, vs, 1'b0, api);
            if (kind == 2) mem[(sb >> 2) + 2 * ix] = mk_tag(1'b1, vs, 1'b1, api);
            if (kind == 3) mem[(pb >> 2) + 2 * ix] = mk_tag(1'b1, vs, 1'b1, api);
            run_case("rand", vs, api, 1'($urandom), 1'($urandom), pb, sb, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule